// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This unit is the register bank of a small LCD controller. A 32-bit word bus reads and writes six registers: a control word, two dimension/timing words, a third timing word, a status word and a subpanel word. The stored fields go out on plain ports to the pixel-fetch, palette and panel-timing blocks. Those blocks report back through three single-cycle event pulses: frame finished, palette loaded and sync error.

The unit keeps the three status flags and merges them into one level interrupt. Frame-done and palette-loaded each have their own enable. Sync-error always raises the interrupt. The unit also updates the flags when software turns the controller on or off. Turning it off clears sync-error and reports a finished frame, except when the palette-load mode is 1. Turning it on clears frame-done and palette-loaded. A sync-error event turns the controller off without these updates.

Reads are registered: data and the error flag appear on the cycle after the request. Writes take effect at the request edge.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every stored field, flag and decoded output is zero, and `irq` is low. A control read then returns 0xFE000C34, a timing0 read returns 0x0000000F, and a timing2 read returns 0xFC000000.
- R2: A control write (offset 0x00) stores the following fields:
  - mode from bits 21:20
  - panel-type flag from bit 7
  - interrupt enables from bits 4:3 (bit 3 for frame-done, bit 4 for palette-loaded)
  - mono from bit 1
  - enable from bit 0
  - the bits under mask 0x01CFF300

  A control read ORs together all of the following:
  - the panel-type flag at bit 23 and again at bit 7
  - mode at bits 21:20
  - the enables at bits 4:3
  - mono at bit 1
  - enable at bit 0
  - the masked bits
  - the constant 0xFE000C34
- R3: For timing0 (0x04) and timing1 (0x08), bits 9:0 hold width−1 and height−1 and drive `cfg_width_m1` and `cfg_height_m1`. Bits 31:10 are stored as written. A timing0 read forces bits 3:0 to one.
- R4: Timing2 (0x0C) stores all 32 bits, and a read forces bits 31:26 to one. A subpanel (0x14) write is ANDed with 0xA1FFFFFF.
- R5: Writes to status (0x10) leave every flag unchanged.
- R6: A read of any offset other than the six listed returns zero, with `bus_err` high for exactly the following cycle. Mapped reads leave `bus_err` low.
- R7: `irq` is high exactly when one of the following holds:
  - frame-done is set and enable bit 3 is set
  - palette-loaded is set and enable bit 4 is set
  - sync-error is set, whatever the enables
- R8: A control write that changes enable from 1 to 0 clears sync-error. It also sets frame-done unless the mode written in that same word is 1.
- R9: A control write that changes enable from 0 to 1 clears frame-done and palette-loaded.
- R10: A `ev_sync_err` pulse sets sync-error and clears enable in the same edge. It does not apply the R8 flag updates.
- R11: The pulses `ev_frame_done` and `ev_palette_done` set their flags. A status read shows palette-loaded at bit 6, sync-error at bit 2 and frame-done at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | One-cycle flag for an unmapped read |
| ev_frame_done | input | 1 | Frame finished pulse |
| ev_palette_done | input | 1 | Palette loaded pulse |
| ev_sync_err | input | 1 | Sync error pulse |
| cfg_mode | output | 2 | Palette-load mode |
| cfg_tft | output | 1 | Panel-type flag |
| cfg_mono | output | 1 | Monochrome flag |
| cfg_enable | output | 1 | Controller enable |
| cfg_width_m1 | output | 10 | Width minus one |
| cfg_height_m1 | output | 10 | Height minus one |
| cfg_timing2 | output | 32 | Third timing word |
| cfg_subpanel | output | 32 | Masked subpanel word |
| irq | output | 1 | Level interrupt |

## Verification
The control word is tested with an all-ones pattern and with a single-bit pattern. Together they show that the masks, the forced-one constant and the mirrored panel-type bit are each present and each in the right place. The dimension words use patterns whose upper and lower parts differ, so a wrong split at bit 10 shows up on both the readback and the decoded width and height. The flag sequencing is tested with enable turned off in mode 0 and in mode 1, and with enable turned on after flags were set. This separates the on and off paths, and separates the mode exception from the plain case. The interrupt is tested under each enable alone, so a swapped enable bit or a maskable sync-error is visible.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 8;
  localparam int DIM_W  = 10;
  localparam int HI_W   = WORD_W - DIM_W;

  localparam logic [OFS_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [OFS_W-1:0] OFS_TIM0 = 8'h04;
  localparam logic [OFS_W-1:0] OFS_TIM1 = 8'h08;
  localparam logic [OFS_W-1:0] OFS_TIM2 = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h10;
  localparam logic [OFS_W-1:0] OFS_SUBP = 8'h14;

  localparam logic [WORD_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [WORD_W-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
  localparam logic [WORD_W-1:0] TIM0_RD_ONES   = 32'h0000_000F;
  localparam logic [WORD_W-1:0] TIM2_RD_ONES   = 32'hFC00_0000;
  localparam logic [WORD_W-1:0] SUBP_WR_MASK   = 32'hA1FF_FFFF;

  typedef struct packed {
    logic [1:0]        mode;
    logic              tft;
    logic [1:0]        ien;
    logic              mono;
    logic              en;
    logic [WORD_W-1:0] keep;
  } ctrl_t;

  typedef struct packed {
    logic pal;
    logic sync;
    logic frame;
  } flags_t;

  function automatic logic [WORD_W-1:0] ctrl_word(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = c.keep | CTRL_RD_ONES;
    w[23]    = w[23] | c.tft;
    w[21:20] = w[21:20] | c.mode;
    w[7]     = w[7] | c.tft;
    w[4:3]   = w[4:3] | c.ien;
    w[1]     = w[1] | c.mono;
    w[0]     = w[0] | c.en;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] dim_word(input logic [HI_W-1:0] hi,
                                                 input logic [DIM_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] stat_word(input flags_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[6] = f.pal;
    w[2] = f.sync;
    w[0] = f.frame;
    return w;
  endfunction

  function automatic logic irq_of(input flags_t f, input logic [1:0] ien);
    return (f.frame & ien[0]) | (f.pal & ien[1]) | f.sync;
  endfunction
endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_regbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  wr_tim0,
  input  logic                  wr_tim1,
  input  logic                  wr_tim2,
  input  logic                  wr_subp,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  ev_sync_err,
  output ctrl_t                 ctrl,
  output logic [HI_W-1:0]       tim0_hi,
  output logic [HI_W-1:0]       tim1_hi,
  output logic [DIM_W-1:0]      width_m1,
  output logic [DIM_W-1:0]      height_m1,
  output logic [WORD_W-1:0]     tim2,
  output logic [WORD_W-1:0]     subp,
  output logic                  en_rise,
  output logic                  en_fall,
  output logic [1:0]            fall_mode
);
  assign en_rise   = wr_ctrl &  wdata[0] & ~ctrl.en;
  assign en_fall   = wr_ctrl & ~wdata[0] &  ctrl.en;
  assign fall_mode = wdata[21:20];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      tim0_hi   <= '0;
      tim1_hi   <= '0;
      width_m1  <= '0;
      height_m1 <= '0;
      tim2      <= '0;
      subp      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.mode <= wdata[21:20];
        ctrl.tft  <= wdata[7];
        ctrl.ien  <= wdata[4:3];
        ctrl.mono <= wdata[1];
        ctrl.en   <= wdata[0];
        ctrl.keep <= wdata & CTRL_KEEP_MASK;
      end
      if (ev_sync_err) ctrl.en <= 1'b0;
      if (wr_tim0) {tim0_hi, width_m1}  <= wdata;
      if (wr_tim1) {tim1_hi, height_m1} <= wdata;
      if (wr_tim2) tim2 <= wdata;
      if (wr_subp) subp <= wdata & SUBP_WR_MASK;
    end
  end

  a_r10_sync_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync_err |=> !ctrl.en);
  a_r4_subp_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (subp & ~SUBP_WR_MASK) == '0);
endmodule

// File: rtl/lcd_status_flags.sv
module lcd_status_flags
  import lcd_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic [1:0] fall_mode,
  input  logic       ev_frame_done,
  input  logic       ev_palette_done,
  input  logic       ev_sync_err,
  input  logic [1:0] ien,
  output flags_t     flags,
  output logic       irq
);
  flags_t nxt;

  always_comb begin
    nxt = flags;
    if (en_rise) begin
      nxt.frame = 1'b0;
      nxt.pal   = 1'b0;
    end
    if (en_fall) begin
      nxt.sync = 1'b0;
      if (fall_mode != 2'd1) nxt.frame = 1'b1;
    end
    if (ev_frame_done)   nxt.frame = 1'b1;
    if (ev_palette_done) nxt.pal   = 1'b1;
    if (ev_sync_err)     nxt.sync  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  assign irq = irq_of(flags, ien);

  a_r7_sync_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    flags.sync |-> irq);
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00 && !flags.sync) |-> !irq);
  a_r8_fall_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !ev_sync_err) |=> !flags.sync);
  a_r8_fall_sets_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && fall_mode != 2'd1) |=> flags.frame);
  a_r9_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !ev_frame_done && !ev_palette_done) |=> (!flags.frame && !flags.pal));
endmodule

// File: rtl/lcd_read_port.sv
module lcd_read_port
  import lcd_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  rd_addr,
  input  ctrl_t             ctrl,
  input  logic [HI_W-1:0]   tim0_hi,
  input  logic [HI_W-1:0]   tim1_hi,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [WORD_W-1:0] tim2,
  input  logic [WORD_W-1:0] subp,
  input  flags_t            flags,
  output logic [WORD_W-1:0] rdata,
  output logic              err
);
  logic [WORD_W-1:0] mux;
  logic              miss;

  always_comb begin
    mux  = '0;
    miss = 1'b0;
    unique case (rd_addr)
      OFS_CTRL: mux = ctrl_word(ctrl);
      OFS_TIM0: mux = dim_word(tim0_hi, width_m1) | TIM0_RD_ONES;
      OFS_TIM1: mux = dim_word(tim1_hi, height_m1);
      OFS_TIM2: mux = tim2 | TIM2_RD_ONES;
      OFS_STAT: mux = stat_word(flags);
      OFS_SUBP: mux = subp;
      default:  miss = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= rd_req & miss;
      if (rd_req) rdata <= mux;
    end
  end

  a_r6_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == '0);
  a_r6_err_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_req));
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              ev_frame_done,
  input  logic              ev_palette_done,
  input  logic              ev_sync_err,
  output logic [1:0]        cfg_mode,
  output logic              cfg_tft,
  output logic              cfg_mono,
  output logic              cfg_enable,
  output logic [9:0]        cfg_width_m1,
  output logic [9:0]        cfg_height_m1,
  output logic [31:0]       cfg_timing2,
  output logic [31:0]       cfg_subpanel,
  output logic              irq
);
  logic           wr_en, rd_req;
  ctrl_t          ctrl;
  flags_t         flags;
  logic [HI_W-1:0] tim0_hi, tim1_hi;
  logic           en_rise, en_fall;
  logic [1:0]     fall_mode;

  assign wr_en  = bus_valid &  bus_write;
  assign rd_req = bus_valid & ~bus_write;

  lcd_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_en && bus_addr == OFS_CTRL),
    .wr_tim0(wr_en && bus_addr == OFS_TIM0),
    .wr_tim1(wr_en && bus_addr == OFS_TIM1),
    .wr_tim2(wr_en && bus_addr == OFS_TIM2),
    .wr_subp(wr_en && bus_addr == OFS_SUBP),
    .wdata(bus_wdata), .ev_sync_err(ev_sync_err),
    .ctrl(ctrl), .tim0_hi(tim0_hi), .tim1_hi(tim1_hi),
    .width_m1(cfg_width_m1), .height_m1(cfg_height_m1),
    .tim2(cfg_timing2), .subp(cfg_subpanel),
    .en_rise(en_rise), .en_fall(en_fall), .fall_mode(fall_mode)
  );

  lcd_status_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .en_rise(en_rise), .en_fall(en_fall), .fall_mode(fall_mode),
    .ev_frame_done(ev_frame_done), .ev_palette_done(ev_palette_done),
    .ev_sync_err(ev_sync_err), .ien(ctrl.ien),
    .flags(flags), .irq(irq)
  );

  lcd_read_port u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(bus_addr),
    .ctrl(ctrl), .tim0_hi(tim0_hi), .tim1_hi(tim1_hi),
    .width_m1(cfg_width_m1), .height_m1(cfg_height_m1),
    .tim2(cfg_timing2), .subp(cfg_subpanel), .flags(flags),
    .rdata(bus_rdata), .err(bus_err)
  );

  assign cfg_mode   = ctrl.mode;
  assign cfg_tft    = ctrl.tft;
  assign cfg_mono   = ctrl.mono;
  assign cfg_enable = ctrl.en;

  a_r5_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_STAT && !ev_frame_done && !ev_palette_done && !ev_sync_err)
      |=> $stable(flags));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq && !cfg_enable && !bus_err));
endmodule

// File: tb/lcd_regbank_tb_top.sv
module lcd_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic ev_frame_done = 1'b0, ev_palette_done = 1'b0, ev_sync_err = 1'b0;
  logic [1:0] cfg_mode;
  logic cfg_tft, cfg_mono, cfg_enable, irq;
  logic [9:0] cfg_width_m1, cfg_height_m1;
  logic [31:0] cfg_timing2, cfg_subpanel;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lcd_regbank dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ev_frame_done = 1;
    if (which == 1) ev_palette_done = 1;
    if (which == 2) ev_sync_err = 1;
    @(negedge clk);
    ev_frame_done = 0; ev_palette_done = 0; ev_sync_err = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 enable", {31'd0, cfg_enable}, 0);
    rd(8'h00, d, e); chk("R1 ctrl read", d, 32'hFE000C34);
    rd(8'h04, d, e); chk("R1 timing0 read", d, 32'h0000000F);
    rd(8'h0C, d, e); chk("R1 timing2 read", d, 32'hFC000000);
    rd(8'h10, d, e); chk("R1 status read", d, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d; logic e;
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, d, e); chk("R2 ctrl all ones", d, 32'hFFFFFFBE);
    chk("R2 mode out", {30'd0, cfg_mode}, 3);
    chk("R2 mono out", {31'd0, cfg_mono}, 1);
    wr(8'h00, 32'h0000_0080);
    rd(8'h00, d, e); chk("R2 tft mirrored", d, 32'hFE800CB4);
    chk("R2 tft out", {31'd0, cfg_tft}, 1);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_timing;
    logic [31:0] d; logic e;
    wr(8'h04, 32'hABCD_E123);
    rd(8'h04, d, e); chk("R3 timing0 read", d, 32'hABCDE12F);
    chk("R3 width", {22'd0, cfg_width_m1}, 32'h123);
    wr(8'h08, 32'h1234_57FF);
    rd(8'h08, d, e); chk("R3 timing1 read", d, 32'h123457FF);
    chk("R3 height", {22'd0, cfg_height_m1}, 32'h3FF);
    wr(8'h0C, 32'h0123_4567);
    rd(8'h0C, d, e); chk("R4 timing2 read", d, 32'hFD234567);
    chk("R4 timing2 out", cfg_timing2, 32'h01234567);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d, e); chk("R4 subpanel mask", d, 32'hA1FFFFFF);
  endtask

  task automatic t_events;
    logic [31:0] d; logic e;
    wr(8'h00, 32'h1);
    chk("R9 enable set", {31'd0, cfg_enable}, 1);
    pulse(0);
    rd(8'h10, d, e); chk("R11 frame bit0", d, 32'h1);
    pulse(1);
    rd(8'h10, d, e); chk("R11 palette bit6", d, 32'h41);
    chk("R7 masked irq low", {31'd0, irq}, 0);
    pulse(2);
    rd(8'h10, d, e); chk("R11 sync bit2", d, 32'h45);
    chk("R10 enable cleared", {31'd0, cfg_enable}, 0);
    chk("R7 sync unmasked", {31'd0, irq}, 1);
    wr(8'h10, 32'h0);
    rd(8'h10, d, e); chk("R5 status write ignored", d, 32'h45);
  endtask

  task automatic t_sequence;
    logic [31:0] d; logic e;
    wr(8'h00, 32'h1);
    rd(8'h10, d, e); chk("R9 rise clears frame/pal", d, 32'h4);
    wr(8'h00, 32'h0);
    rd(8'h10, d, e); chk("R8 fall mode0", d, 32'h1);
    chk("R7 no enables", {31'd0, irq}, 0);
    wr(8'h00, 32'h08);
    chk("R7 frame enable", {31'd0, irq}, 1);
    wr(8'h00, 32'h10);
    chk("R7 frame masked by bit4", {31'd0, irq}, 0);
    pulse(1);
    chk("R7 palette enable", {31'd0, irq}, 1);
    wr(8'h00, 32'h11);
    rd(8'h10, d, e); chk("R9 rise clears", d, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 0);
    wr(8'h00, 32'h0010_0001);
    wr(8'h00, 32'h0010_0000);
    rd(8'h10, d, e); chk("R8 fall mode1 no frame", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    rd(8'h18, d, e);
    chk("R6 unmapped data", d, 0);
    chk("R6 unmapped err", {31'd0, e}, 1);
    @(negedge clk);
    chk("R6 err one cycle", {31'd0, bus_err}, 0);
    rd(8'h02, d, e);
    chk("R6 misaligned err", {31'd0, e}, 1);
    rd(8'h14, d, e);
    chk("R6 mapped no err", {31'd0, e}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_timing();
    t_events();
    t_sequence();
    t_unmapped();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule